// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block produces the programmed-I/O read and write strobes that a local-bus host uses to reach the registers and data port of an IDE device. Each channel has an 8-bit timing byte, written through a small configuration port. The low nibble of that byte sets how long the strobe is held asserted, and the high nibble sets how long the strobe is held high before the next access may begin. Both durations are counted in local-bus clocks. Each duration is encoded as an inverted offset from a fixed maximum, so a byte of zero gives the longest timing.

A request carries a direction and a channel select. When the block is idle, `ready_o` is high and it accepts the request. It decodes the selected timing byte once, at acceptance. It then drives the matching strobe low for the active period and holds it high for the recovery period. After that it raises `done_o` for one clock and becomes ready again.

A variant input selects one of two encodings:
- The dual-channel encoding is used when `variant_i` is 0.
- The single-channel encoding is used when `variant_i` is 1. It has one channel only, and its active range depends on a bus-speed strap.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset, all read and write strobes are high (deasserted), `ready_o` is 1 and `done_o` is 0. Whenever the block is idle, every strobe is high.
- R2: In the dual-channel encoding (`variant_i`=0), the strobe stays low for exactly 17 − timing[3:0] clocks. The range is 2..17.
- R3: In the dual-channel encoding, the strobe stays high for 15 − timing[7:4] clocks of recovery before `done_o`. Results below 2 (high nibble 14 or 15) are raised to 2, so recovery is always 2..15.
- R4: In the single-channel encoding with `slow_bus_i`=1, the active length is 9 − timing[2:0] clocks (2..9) and the recovery length is 15 − timing[7:4] clocks (0..15). Timing bit 3 has no effect.
- R5: In the single-channel encoding with `slow_bus_i`=0, the active length is 8 − timing[2:0] clocks (1..8) and the recovery length is 18 − timing[7:4] clocks (3..18). Timing bit 3 has no effect.
- R6: A request is accepted only on a rising edge where both `req_i` and `ready_o` are 1. The strobe goes low in the very next clock. Requests seen while busy are dropped. `done_o` is high for exactly one clock, in the first idle clock after recovery.
- R7: With a recovery length of zero, the clock after the last active clock is the done clock. A request presented in that clock starts a new strobe on the following clock.
- R8: The timing byte, variant and strap are sampled at acceptance. A configuration write made during an access changes only later accesses.
- R9: After reset, every channel's timing byte is 0x00, which is the slowest setting in each encoding.
- R10: `we_i`=0 drives `rd_n_o[ch]` and `we_i`=1 drives `wr_n_o[ch]`. In the dual-channel encoding, ch is `chan_i`, and the timing comes from that channel's byte. In the single-channel encoding, ch is always 0 and the timing comes from channel 0's byte, whatever `chan_i` is.
- R11: At most one strobe line across all channels is low in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local-bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write the timing byte of `cfg_chan_i` |
| cfg_chan_i | input | CHW | Channel whose timing byte is written |
| cfg_timing_i | input | TW | New timing byte |
| variant_i | input | 1 | 0 = dual-channel encoding, 1 = single-channel encoding |
| slow_bus_i | input | 1 | Bus-speed strap: 1 = bus at or below 33 MHz |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write strobe, 0 = read strobe |
| chan_i | input | CHW | Channel of the access |
| ready_o | output | 1 | Idle; a request is accepted on this edge |
| done_o | output | 1 | One-clock pulse when the access and its recovery are complete |
| rd_n_o | output | NCH | Active-low read strobes, one per channel |
| wr_n_o | output | NCH | Active-low write strobes, one per channel |

## Verification
The bench measures the low and high run lengths of the strobe at both ends of every nibble range, in each of the three encodings. A clamp that was missing would show a one- or zero-clock dual recovery, and an active field that used bit 3 would shorten single-channel strobes by eight clocks. It chains accesses that have zero recovery: an extra idle cycle would delay the second strobe, and dropping the done clock would make the second strobe start early. It also rewrites the timing byte and pokes a request in the middle of an access. A design that did not latch its inputs at acceptance would stretch or cut the running strobe, or would start a strobe on the other channel.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int CNT_W = 5;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ACT  = 2'd1,
    S_REC  = 2'd2
  } pio_state_e;
endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs #(
  parameter int NCH = 2,
  parameter int TW  = 8,
  parameter logic [TW-1:0] RST_TIMING = '0,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [CHW-1:0]         chan_i,
  input  logic [TW-1:0]          data_i,
  output logic [NCH-1:0][TW-1:0] timing_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         timing_o[g] <= RST_TIMING;
      else if (we_i && chan_i == CHW'(g))  timing_o[g] <= data_i;
    end
  end
endmodule

// File: rtl/pio_timing_decode.sv
module pio_timing_decode #(
  parameter int TW = 8,
  parameter int CW = pio_pkg::CNT_W
) (
  input  logic [TW-1:0] timing_i,
  input  logic          variant_i,
  input  logic          slow_bus_i,
  output logic [CW-1:0] act_o,
  output logic [CW-1:0] rec_o
);
  localparam logic [CW-1:0] DUAL_ACT_MAX = CW'(17);
  localparam logic [CW-1:0] DUAL_REC_MAX = CW'(15);
  localparam logic [CW-1:0] DUAL_REC_MIN = CW'(2);
  localparam logic [CW-1:0] SLOW_ACT_MAX = CW'(9);
  localparam logic [CW-1:0] SLOW_REC_MAX = CW'(15);
  localparam logic [CW-1:0] FAST_ACT_MAX = CW'(8);
  localparam logic [CW-1:0] FAST_REC_MAX = CW'(18);

  logic [CW-1:0] lo_w, hi_w, fld_w, dual_rec_w;

  always_comb begin
    lo_w       = CW'(timing_i[3:0]);
    hi_w       = CW'(timing_i[7:4]);
    fld_w      = CW'(timing_i[2:0]);   // bit 3 is a fixed marker in single mode
    dual_rec_w = DUAL_REC_MAX - hi_w;
    if (!variant_i) begin
      act_o = DUAL_ACT_MAX - lo_w;
      rec_o = (dual_rec_w < DUAL_REC_MIN) ? DUAL_REC_MIN : dual_rec_w;
    end else if (slow_bus_i) begin
      act_o = SLOW_ACT_MAX - fld_w;
      rec_o = SLOW_REC_MAX - hi_w;
    end else begin
      act_o = FAST_ACT_MAX - fld_w;
      rec_o = FAST_REC_MAX - hi_w;
    end
  end
endmodule

// File: rtl/pio_strobe_fsm.sv
module pio_strobe_fsm #(
  parameter int CHW = 1,
  parameter int CW  = pio_pkg::CNT_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [CHW-1:0] chan_i,
  input  logic [CW-1:0]  act_i,
  input  logic [CW-1:0]  rec_i,
  output logic           ready_o,
  output logic           done_o,
  output logic           strobe_o,
  output logic           wr_o,
  output logic [CHW-1:0] chan_o
);
  import pio_pkg::*;

  pio_state_e    state_q;
  logic [CW-1:0] cnt_q, rec_q;

  assign ready_o = (state_q == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      cnt_q    <= '0;
      rec_q    <= '0;
      done_o   <= 1'b0;
      strobe_o <= 1'b0;
      wr_o     <= 1'b0;
      chan_o   <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_i) begin
          state_q  <= S_ACT;
          cnt_q    <= act_i - CW'(1);
          rec_q    <= rec_i;
          strobe_o <= 1'b1;
          wr_o     <= we_i;
          chan_o   <= chan_i;
        end
        S_ACT: begin
          if (cnt_q == '0) begin
            strobe_o <= 1'b0;
            if (rec_q == '0) begin
              state_q <= S_IDLE;
              done_o  <= 1'b1;
            end else begin
              state_q <= S_REC;
              cnt_q   <= rec_q - CW'(1);
            end
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        S_REC: begin
          if (cnt_q == '0) begin
            state_q <= S_IDLE;
            done_o  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_idle_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !strobe_o);
  p_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> (strobe_o && !ready_o));
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ready_o && !strobe_o));
  p_busy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && !ready_o && $past(strobe_o)) |-> ($stable(chan_o) && $stable(wr_o)));
endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen #(
  parameter int NCH = 2,
  parameter int TW  = 8,
  parameter int CW  = pio_pkg::CNT_W,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [CHW-1:0] cfg_chan_i,
  input  logic [TW-1:0]  cfg_timing_i,
  input  logic           variant_i,
  input  logic           slow_bus_i,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [CHW-1:0] chan_i,
  output logic           ready_o,
  output logic           done_o,
  output logic [NCH-1:0] rd_n_o,
  output logic [NCH-1:0] wr_n_o
);
  logic [NCH-1:0][TW-1:0] tbl_w;
  logic [CHW-1:0]         eff_chan_w, cur_chan_w;
  logic [CW-1:0]          act_w, rec_w;
  logic                   strobe_w, cur_wr_w;

  // single-channel variant has only channel 0
  assign eff_chan_w = variant_i ? '0 : chan_i;

  pio_timing_regs #(.NCH(NCH), .TW(TW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .chan_i   (cfg_chan_i),
    .data_i   (cfg_timing_i),
    .timing_o (tbl_w)
  );

  pio_timing_decode #(.TW(TW), .CW(CW)) u_dec (
    .timing_i   (tbl_w[eff_chan_w]),
    .variant_i  (variant_i),
    .slow_bus_i (slow_bus_i),
    .act_o      (act_w),
    .rec_o      (rec_w)
  );

  pio_strobe_fsm #(.CHW(CHW), .CW(CW)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .chan_i   (eff_chan_w),
    .act_i    (act_w),
    .rec_i    (rec_w),
    .ready_o  (ready_o),
    .done_o   (done_o),
    .strobe_o (strobe_w),
    .wr_o     (cur_wr_w),
    .chan_o   (cur_chan_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign rd_n_o[g] = !(strobe_w && !cur_wr_w && cur_chan_w == CHW'(g));
    assign wr_n_o[g] = !(strobe_w &&  cur_wr_w && cur_chan_w == CHW'(g));
  end

  p_one_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~rd_n_o, ~wr_n_o}) <= 1);
  p_act_min_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_w >= CW'(1));
  p_dual_rec_min_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !variant_i |-> rec_w >= CW'(2));
  p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (&rd_n_o && &wr_n_o));
endmodule

// File: tb/pio_strobe_gen_test.sv
module pio_strobe_gen_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [0:0] cfg_chan_i = '0;
  logic [7:0] cfg_timing_i = '0;
  logic       variant_i = 1'b0;
  logic       slow_bus_i = 1'b0;
  logic       req_i = 1'b0;
  logic       we_i = 1'b0;
  logic [0:0] chan_i = '0;
  logic       ready_o, done_o;
  logic [1:0] rd_n_o, wr_n_o;

  int checks = 0;
  int errors = 0;
  int tm[2] = '{0, 0};

  always #10 clk = ~clk;

  pio_strobe_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_chan_i(cfg_chan_i),
    .cfg_timing_i(cfg_timing_i), .variant_i(variant_i), .slow_bus_i(slow_bus_i),
    .req_i(req_i), .we_i(we_i), .chan_i(chan_i), .ready_o(ready_o),
    .done_o(done_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_act(bit v, bit s, int b);
    if (!v) return 17 - (b & 15);
    if (s)  return 9 - (b & 7);
    return 8 - (b & 7);
  endfunction

  function automatic int exp_rec(bit v, bit s, int b);
    int hi = (b >> 4) & 15;
    if (!v) return (15 - hi < 2) ? 2 : 15 - hi;
    if (s)  return 15 - hi;
    return 18 - hi;
  endfunction

  function automatic bit line_low(bit w, int c);
    return w ? !wr_n_o[c] : !rd_n_o[c];
  endfunction

  function automatic int n_low();
    return $countones(~rd_n_o) + $countones(~wr_n_o);
  endfunction

  // called at a negedge
  task automatic cfg_write(int c, int b);
    cfg_we_i = 1'b1; cfg_chan_i = c[0]; cfg_timing_i = b[7:0];
    @(negedge clk);
    cfg_we_i = 1'b0;
    tm[c] = b;
  endtask

  // entered at a negedge with the block idle; returns at the negedge of the done clock
  // disturb: 0 none, 1 poke a foreign request, 2 rewrite the timing byte
  task automatic access(bit w, int c, bit v, bit s, int disturb, int nb,
                        string ta, string tr, bit chain);
    int ec = v ? 0 : c;
    int b  = tm[ec];
    int ea = exp_act(v, s, b);
    int er = exp_rec(v, s, b);
    int lo = 0, hi = 0, guard = 0, extra = 0;
    chk("R6 ready before request", ready_o, 1);
    variant_i = v; slow_bus_i = s; we_i = w; chan_i = c[0]; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    while (line_low(w, ec) && guard < 60) begin
      if (n_low() != 1) extra++;
      if (lo == 0 && disturb == 1) begin
        req_i = 1'b1; chan_i = ~c[0]; we_i = ~w;
      end
      if (lo == 0 && disturb == 2) begin
        cfg_we_i = 1'b1; cfg_chan_i = ec[0]; cfg_timing_i = nb[7:0];
      end
      lo++; guard++;
      @(negedge clk);
      if (lo == 1) begin
        req_i = 1'b0; cfg_we_i = 1'b0;
        if (disturb == 2) tm[ec] = nb;
      end
    end
    while (!done_o && n_low() == 0 && guard < 60) begin
      hi++; guard++;
      @(negedge clk);
    end
    chk({ta, " active clocks"}, lo, ea);
    chk({tr, " recovery clocks"}, hi, er);
    chk("R11 single strobe line", extra, 0);
    chk("R6 done after recovery", done_o, 1);
    chk("R6 ready with done", ready_o, 1);
    if (!chain) begin
      @(negedge clk);
      chk("R6 done one clock", done_o, 0);
      chk(disturb == 1 ? "R6 busy request dropped" : "R1 idle lines high", n_low(), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset rd lines", rd_n_o, 3);
    chk("R1 reset wr lines", wr_n_o, 3);
    chk("R1 reset ready", ready_o, 1);
    chk("R1 reset done", done_o, 0);

    // R9 slowest defaults
    access(0, 0, 0, 0, 0, 0, "R9 dual", "R9 dual", 0);
    access(1, 1, 1, 0, 0, 0, "R9 fast", "R9 fast", 0);
    access(0, 1, 1, 1, 0, 0, "R9 slow", "R9 slow", 0);

    // R2 / R3 range ends and clamp
    cfg_write(0, 8'h0F);
    access(1, 0, 0, 1, 0, 0, "R2 min", "R3", 0);
    cfg_write(1, 8'hF0);
    access(0, 1, 0, 0, 0, 0, "R2 max", "R3 clamp hi=15", 0);
    cfg_write(1, 8'hE3);
    access(1, 1, 0, 0, 0, 0, "R2", "R3 clamp hi=14", 0);
    cfg_write(1, 8'hD3);
    access(1, 1, 0, 0, 0, 0, "R2", "R3 hi=13", 0);

    // R4 / R5 bit 3 ignored
    cfg_write(0, 8'h0F);
    access(0, 0, 1, 1, 0, 0, "R4 bit3 set", "R4", 0);
    cfg_write(0, 8'h07);
    access(0, 0, 1, 1, 0, 0, "R4 bit3 clear", "R4", 0);
    cfg_write(0, 8'hF8);
    access(1, 0, 1, 1, 0, 0, "R4 max", "R4 zero", 0);
    cfg_write(0, 8'h0F);
    access(1, 0, 1, 0, 0, 0, "R5 min", "R5 max", 0);
    cfg_write(0, 8'hF8);
    access(0, 0, 1, 0, 0, 0, "R5 max", "R5 min", 0);

    // R10 single variant forces channel 0 and its byte
    cfg_write(0, 8'h34);
    cfg_write(1, 8'h00);
    access(0, 1, 1, 1, 0, 0, "R10 single ch1->ch0", "R10", 0);
    access(1, 1, 1, 0, 0, 0, "R10 single wr ch0", "R10", 0);
    access(1, 1, 0, 0, 0, 0, "R10 dual ch1", "R10", 0);

    // R7 zero recovery back to back
    cfg_write(0, 8'hFE);
    access(0, 0, 1, 1, 0, 0, "R7 first", "R7 first", 1);
    access(1, 0, 1, 1, 0, 0, "R7 chained", "R7 chained", 1);
    access(0, 0, 1, 1, 0, 0, "R7 chained again", "R7", 0);

    // R6 request while busy is dropped
    cfg_write(0, 8'h5A);
    access(0, 0, 0, 0, 1, 0, "R6 poke", "R6 poke", 0);

    // R8 timing rewrite during access
    cfg_write(0, 8'h55);
    access(0, 0, 0, 0, 2, 8'hA3, "R8 old byte", "R8 old byte", 0);
    access(1, 0, 0, 0, 0, 0, "R8 new byte", "R8 new byte", 0);

    // random mix
    for (int i = 0; i < 150; i++) begin
      bit v = 1'($urandom_range(0, 1));
      bit s = 1'($urandom_range(0, 1));
      bit w = 1'($urandom_range(0, 1));
      int c = $urandom_range(0, 1);
      int b = $urandom_range(0, 255);
      if (v) b = b | 8;
      cfg_write(c, b);
      access(w, c, v, s, 0, 0,
             v ? (s ? "R4 random" : "R5 random") : "R2 random",
             v ? (s ? "R4 random" : "R5 random") : "R3 random",
             1'($urandom_range(0, 1)));
      if (i % 40 == 0) @(negedge clk);
    end

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule